// File: doc/BRIEF.md
# Bunch Lane Demultiplexer and Remultiplexer

This block sits between the fast sample converters of a bunch-by-bunch feedback processor and its filter bank. Every fabric clock, the analog-to-digital converter side delivers one wide word that carries `LANES` consecutive bunch samples. Because two converter cores sample alternately, the samples in that word are not in ascending bunch order. The block sorts each sample onto the lane that belongs to its bunch offset. It also tags each lane with the absolute bunch number inside the machine turn. The filter logic can then run at the bunch rate divided by `LANES`.

On the return path, the block takes one kick value per lane and rebuilds the wide word in the field order the digital-to-analog converter expects. It uses the exact inverse of the input mapping. A kick computed from a lane's own samples therefore lands back in that bunch's time slot.

Both paths have a fixed latency that is a whole number of fabric clocks, so every kick reaches the same bunch on every turn. The harmonic number `HARMONIC` must be a multiple of `LANES`, and `LANES` must be even. The permutation is a parameter, so other converter arrangements can be supported.

Top module: `bbf_lane_mux`

## Requirements
- R1: Field p of `adc_word_i` occupies bits [p*SAMP_W +: SAMP_W], with p = 0 the earliest sample. It holds the bunch whose offset in the group is PERM(p). The default is PERM(p) = (p mod 2)*(LANES/2) + floor(p/2), so the default field order is 0, 4, 1, 5, 2, 6, 3, 7. Lane k of `lane_samp_o` (bits [k*SAMP_W +: SAMP_W]) shows the field with PERM(p) = k, one clock after the word is presented.
- R2: Lane k of `lane_bunch_o` (bits [k*BIDX_W +: BIDX_W]) equals G*LANES + k. G is the group number of the word shown on `lane_samp_o` in the same cycle.
- R3: A word presented with `turn_mark_i` high is group 0, even in the middle of a turn.
- R4: A word presented without the marker gets the previous group plus one. The group wraps from HARMONIC/LANES-1 to 0.
- R5: While reset is low, `lane_samp_o` and `dac_word_o` are zero, and the group reads HARMONIC/LANES-1. The first word after reset, with no marker, is therefore group 0.
- R6: Field p of `dac_word_o` (bits [p*KICK_W +: KICK_W]) equals lane PERM(p) of `kick_lane_i`, exactly TX_STAGES clocks later (default 2).
- R7: Feeding each lane sample back unchanged as that lane's kick reproduces every converter field at its original position, 1+TX_STAGES clocks after the word entered.
- R8: Full-scale values (all ones) in some fields and zeros in others stay in their own fields on both paths, with no spill into neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock, bunch rate / LANES |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adc_word_i | input | LANES*SAMP_W | Converter word, interleaved sample order |
| turn_mark_i | input | 1 | High with the word that starts a turn |
| lane_samp_o | output | LANES*SAMP_W | Samples sorted by bunch offset |
| lane_bunch_o | output | LANES*BIDX_W | Absolute bunch number per lane |
| kick_lane_i | input | LANES*KICK_W | Kick value per lane |
| dac_word_o | output | LANES*KICK_W | Kick word in converter field order |

## Verification
A wrong entry in the input mapping shows up one clock later as a sample on the wrong lane. The same fault on the output side sends a kick to the wrong time slot after TX_STAGES clocks, and a loopback run shows both at once. A group counter that has drifted gives wrong bunch numbers on every lane in the next cycle. Such a counter also fails the wrap and the mid-turn resync to zero at the first marker or the first turn boundary. The directed sequence crosses both events in its first dozen words.

// File: rtl/bbf_lane_pkg.sv
package bbf_lane_pkg;

    localparam int PERM_FW   = 8;
    localparam int MAX_LANES = 32;

    typedef logic [MAX_LANES*PERM_FW-1:0] perm_vec_t;

    // Dual-core interleave: even fields come from the first core (lower
    // half of the group), odd fields from the second core (upper half).
    function automatic perm_vec_t interleave_perm(int lanes);
        perm_vec_t v;
        v = '0;
        for (int p = 0; p < lanes && p < MAX_LANES; p++) begin
            v[p*PERM_FW +: PERM_FW] = PERM_FW'((p % 2) * (lanes / 2) + p / 2);
        end
        return v;
    endfunction

    function automatic int perm_at(perm_vec_t v, int p);
        return int'(v[p*PERM_FW +: PERM_FW]);
    endfunction

endpackage

// File: rtl/bbf_lane_demux.sv
module bbf_lane_demux
    import bbf_lane_pkg::*;
#(
    parameter int        LANES     = 8,
    parameter int        SAMP_W    = 12,
    parameter perm_vec_t LANE_PERM = interleave_perm(8)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [LANES*SAMP_W-1:0]  word_i,
    output logic [LANES*SAMP_W-1:0]  lane_o
);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef logic [LANES-1:0][SAMP_W-1:0] lanes_t;
    typedef struct packed {
        lanes_t lane;
    } state_t;

    state_t state_d, state_q;
    lanes_t word;

    assign word = word_i;

    always_comb begin
        state_d = state_q;
        for (int p = 0; p < LANES; p++) begin
            state_d.lane[IDX_W'(perm_at(LANE_PERM, p))] = word[p];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign lane_o = state_q.lane;

endmodule

// File: rtl/bbf_bunch_ctr.sv
module bbf_bunch_ctr #(
    parameter int LANES    = 8,
    parameter int HARMONIC = 32,
    parameter int BIDX_W   = $clog2(HARMONIC)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     turn_mark_i,
    output logic [LANES*BIDX_W-1:0]  bunch_o
);
    localparam int GROUPS = HARMONIC / LANES;
    localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam logic [GRP_W-1:0] LAST = GRP_W'(GROUPS - 1);

    typedef struct packed {
        logic [GRP_W-1:0] grp;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (turn_mark_i || state_q.grp == LAST) state_d.grp = '0;
        else                                    state_d.grp = state_q.grp + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '{grp: LAST};
        else         state_q <= state_d;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane_idx
        assign bunch_o[k*BIDX_W +: BIDX_W] = BIDX_W'(int'(state_q.grp) * LANES + k);
    end

endmodule

// File: rtl/bbf_lane_remux.sv
module bbf_lane_remux
    import bbf_lane_pkg::*;
#(
    parameter int        LANES     = 8,
    parameter int        KICK_W    = 14,
    parameter int        TX_STAGES = 2,
    parameter perm_vec_t LANE_PERM = interleave_perm(8)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [LANES*KICK_W-1:0]  kick_i,
    output logic [LANES*KICK_W-1:0]  word_o
);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef logic [LANES-1:0][KICK_W-1:0] word_t;
    typedef struct packed {
        logic [TX_STAGES-1:0][LANES-1:0][KICK_W-1:0] pipe;
    } state_t;

    state_t state_d, state_q;
    word_t  kick;

    assign kick = kick_i;

    always_comb begin
        state_d = state_q;
        for (int p = 0; p < LANES; p++) begin
            state_d.pipe[0][p] = kick[IDX_W'(perm_at(LANE_PERM, p))];
        end
        for (int s = 1; s < TX_STAGES; s++) begin
            state_d.pipe[s] = state_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign word_o = state_q.pipe[TX_STAGES-1];

endmodule

// File: rtl/bbf_lane_mux.sv
module bbf_lane_mux
    import bbf_lane_pkg::*;
#(
    parameter int        LANES     = 8,
    parameter int        SAMP_W    = 12,
    parameter int        KICK_W    = 14,
    parameter int        HARMONIC  = 32,
    parameter int        TX_STAGES = 2,
    parameter int        BIDX_W    = $clog2(HARMONIC),
    parameter perm_vec_t LANE_PERM = interleave_perm(LANES)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [LANES*SAMP_W-1:0]  adc_word_i,
    input  logic                     turn_mark_i,
    output logic [LANES*SAMP_W-1:0]  lane_samp_o,
    output logic [LANES*BIDX_W-1:0]  lane_bunch_o,
    input  logic [LANES*KICK_W-1:0]  kick_lane_i,
    output logic [LANES*KICK_W-1:0]  dac_word_o
);

    bbf_lane_demux #(
        .LANES     (LANES),
        .SAMP_W    (SAMP_W),
        .LANE_PERM (LANE_PERM)
    ) rx_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .word_i (adc_word_i),
        .lane_o (lane_samp_o)
    );

    bbf_bunch_ctr #(
        .LANES    (LANES),
        .HARMONIC (HARMONIC),
        .BIDX_W   (BIDX_W)
    ) ctr_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .turn_mark_i (turn_mark_i),
        .bunch_o     (lane_bunch_o)
    );

    bbf_lane_remux #(
        .LANES     (LANES),
        .KICK_W    (KICK_W),
        .TX_STAGES (TX_STAGES),
        .LANE_PERM (LANE_PERM)
    ) tx_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .kick_i (kick_lane_i),
        .word_o (dac_word_o)
    );

endmodule

// File: rtl/bbf_lane_mux_chk.sv
module bbf_lane_mux_chk
    import bbf_lane_pkg::*;
#(
    parameter int        LANES     = 8,
    parameter int        SAMP_W    = 12,
    parameter int        KICK_W    = 14,
    parameter int        HARMONIC  = 32,
    parameter int        TX_STAGES = 2,
    parameter int        BIDX_W    = $clog2(HARMONIC),
    parameter perm_vec_t LANE_PERM = interleave_perm(LANES)
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic [LANES*SAMP_W-1:0]  adc_word_i,
    input logic                     turn_mark_i,
    input logic [LANES*SAMP_W-1:0]  lane_samp_o,
    input logic [LANES*BIDX_W-1:0]  lane_bunch_o,
    input logic [LANES*KICK_W-1:0]  kick_lane_i,
    input logic [LANES*KICK_W-1:0]  dac_word_o
);
    logic [7:0]        live_q;
    logic [BIDX_W-1:0] bunch0;

    assign bunch0 = lane_bunch_o[BIDX_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   live_q <= '0;
        else if (live_q < 8'(TX_STAGES)) live_q <= live_q + 8'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk_i) $rose(rst_ni) |-> (lane_samp_o == '0 && dac_word_o == '0)); // R5

    AST_TURN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) turn_mark_i |=> bunch0 == '0); // R3

    AST_GROUP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) !turn_mark_i |=> bunch0 == BIDX_W'((int'($past(bunch0)) + LANES) % HARMONIC)); // R4

    for (genvar p = 0; p < LANES; p++) begin : g_field
        localparam int LN = perm_at(LANE_PERM, p);

        AST_LANE_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni) rst_ni |=> lane_samp_o[LN*SAMP_W +: SAMP_W] == $past(adc_word_i[p*SAMP_W +: SAMP_W])); // R1

        if (TX_STAGES == 1) begin : g_tx1
            AST_TX_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni) (live_q >= 8'(TX_STAGES)) |-> dac_word_o[p*KICK_W +: KICK_W] == $past(kick_lane_i[LN*KICK_W +: KICK_W])); // R6
        end else if (TX_STAGES == 2) begin : g_tx2
            AST_TX_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni) (live_q >= 8'(TX_STAGES)) |-> dac_word_o[p*KICK_W +: KICK_W] == $past(kick_lane_i[LN*KICK_W +: KICK_W], 2)); // R6
        end
    end

endmodule

bind bbf_lane_mux bbf_lane_mux_chk #(
    .LANES     (LANES),
    .SAMP_W    (SAMP_W),
    .KICK_W    (KICK_W),
    .HARMONIC  (HARMONIC),
    .TX_STAGES (TX_STAGES),
    .BIDX_W    (BIDX_W),
    .LANE_PERM (LANE_PERM)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adc_word_i   (adc_word_i),
    .turn_mark_i  (turn_mark_i),
    .lane_samp_o  (lane_samp_o),
    .lane_bunch_o (lane_bunch_o),
    .kick_lane_i  (kick_lane_i),
    .dac_word_o   (dac_word_o)
);

// File: tb/bbf_lane_mux_tb_top.sv
module bbf_lane_mux_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int L   = 8;
    localparam int SW  = 12;
    localparam int KW  = 14;
    localparam int H   = 32;
    localparam int G   = H / L;
    localparam int BW  = 5;
    localparam int NV  = 10;

    typedef struct packed {
        logic        turn;
        logic [1:0]  mode;
        logic [11:0] seed;
    } vec_t;

    // turn, mode (0 ramp, 1 alternate full-scale/zero, 2 all ones), seed
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 12'h123}, '{1'b0, 2'd0, 12'h456}, '{1'b0, 2'd1, 12'h000},
        '{1'b0, 2'd0, 12'h789}, '{1'b0, 2'd2, 12'h000}, '{1'b0, 2'd0, 12'hABC},
        '{1'b1, 2'd0, 12'h0F0}, '{1'b0, 2'd1, 12'h000}, '{1'b0, 2'd0, 12'h5A5},
        '{1'b0, 2'd2, 12'h000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [L*SW-1:0] adc_word = '0;
    logic            turn_mark = 1'b0;
    logic [L*SW-1:0] lane_samp;
    logic [L*BW-1:0] lane_bunch;
    logic [L*KW-1:0] kick_lane = '0;
    logic [L*KW-1:0] dac_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bbf_lane_mux dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .adc_word_i   (adc_word),
        .turn_mark_i  (turn_mark),
        .lane_samp_o  (lane_samp),
        .lane_bunch_o (lane_bunch),
        .kick_lane_i  (kick_lane),
        .dac_word_o   (dac_word)
    );

    // Field position carrying bunch offset k (inverse of the interleave rule)
    function automatic int pos_of(int k);
        return (k < L/2) ? 2*k : 2*(k - L/2) + 1;
    endfunction

    function automatic logic [L*SW-1:0] mk_word(vec_t v);
        logic [L*SW-1:0] w;
        for (int p = 0; p < L; p++) begin
            case (v.mode)
                2'd0:    w[p*SW +: SW] = v.seed + 12'(37*p);
                2'd1:    w[p*SW +: SW] = (p % 2 == 0) ? 12'hFFF : 12'h000;
                default: w[p*SW +: SW] = 12'hFFF;
            endcase
        end
        return w;
    endfunction

    function automatic logic [L*KW-1:0] mk_kick(vec_t v);
        logic [L*KW-1:0] w;
        for (int k = 0; k < L; k++) begin
            case (v.mode)
                2'd0:    w[k*KW +: KW] = 14'(int'(v.seed)*3 + 101*k);
                2'd1:    w[k*KW +: KW] = (k % 2 == 1) ? 14'h3FFF : 14'h0000;
                default: w[k*KW +: KW] = 14'h3FFF;
            endcase
        end
        return w;
    endfunction

    function automatic logic [L*SW-1:0] exp_lanes(logic [L*SW-1:0] w);
        logic [L*SW-1:0] r;
        for (int k = 0; k < L; k++) r[k*SW +: SW] = w[pos_of(k)*SW +: SW];
        return r;
    endfunction

    function automatic logic [L*KW-1:0] exp_dac(logic [L*KW-1:0] kk);
        logic [L*KW-1:0] r;
        for (int k = 0; k < L; k++) r[pos_of(k)*KW +: KW] = kk[k*KW +: KW];
        return r;
    endfunction

    function automatic logic [L*BW-1:0] exp_bunch(int g);
        logic [L*BW-1:0] r;
        for (int k = 0; k < L; k++) r[k*BW +: BW] = BW'(g*L + k);
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        int grp;
        logic [L*SW-1:0] w_keep;

        // Reset state (R5)
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R5 reset lanes", lane_samp, '0);
        chk("R5 reset bunch", lane_bunch, exp_bunch(G-1));
        chk("R5 reset dac", dac_word, '0);

        // Table walk (R1, R2, R3, R4, R6, R8)
        rst_n = 1'b1;
        grp = G - 1;
        adc_word  = mk_word(VECS[0]);
        turn_mark = VECS[0].turn;
        kick_lane = mk_kick(VECS[0]);
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            @(negedge clk);
            grp = VECS[i].turn ? 0 : (grp + 1) % G;
            chk("R1 R8 lane sort", lane_samp, exp_lanes(mk_word(VECS[i])));
            chk("R2 R3 R4 bunch index", lane_bunch, exp_bunch(grp));
            if (i >= 1) chk("R6 R8 dac order", dac_word, exp_dac(mk_kick(VECS[i-1])));
            if (i < NV-1) begin
                adc_word  = mk_word(VECS[i+1]);
                turn_mark = VECS[i+1].turn;
                kick_lane = mk_kick(VECS[i+1]);
            end
        end

        // Reset mid-stream, then first word without marker is group 0 (R5)
        rst_n = 1'b0;
        turn_mark = 1'b0;
        adc_word = mk_word(VECS[5]);
        #1;
        chk("R5 async clear lanes", lane_samp, '0);
        chk("R5 async clear bunch", lane_bunch, exp_bunch(G-1));
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R5 first group after reset", lane_bunch, exp_bunch(0));

        // Loopback (R7)
        w_keep = mk_word(VECS[8]);
        adc_word = w_keep;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < L; k++) kick_lane[k*KW +: KW] = {2'b00, lane_samp[k*SW +: SW]};
        adc_word = mk_word(VECS[3]);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        begin
            logic [L*KW-1:0] exp_lb;
            for (int p = 0; p < L; p++) exp_lb[p*KW +: KW] = {2'b00, w_keep[p*SW +: SW]};
            chk("R7 loopback order", dac_word, exp_lb);
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule